// File: doc/BRIEF.md
# Memory-Space Chip-Select Decoder

This block decodes each bus cycle of a signal processor that keeps three separate address spaces: program, data and I/O. From the space-select lines, the memory and I/O strobes and a 22-bit word address it produces two kinds of output. The first is one select for an on-chip 64K-word SRAM. The second is a set of six active-low chip selects for devices on a secondary bus. It also produces a flag that tells a bus repeater whether the current cycle should be copied onto the secondary bus.

Software sets up the mapping before it is used. A write port accepts register writes only while the program-enable input is high. One configuration register places the two 32K-word SRAM halves. Five further registers each describe one external device window. Each window is made of 8K-word blocks and is selected by address bits 21:13. The sixth external select is a default select. It fires when a validated access matches nothing else.

All decoding is combinational from the bus inputs, so every select follows its strobe within the same cycle. Only the configuration is held in flip-flops.

Top module: `spdec_top`

## Requirements
- R1: After reset every configuration register is zero. A validated access then asserts only `extCsN[0]` (value 6'b111110), `sramSel` stays 0 and `fwdCycle` is 1.
- R2: A program or data access is validated only while `memStrobe` is 1. An I/O access is validated only while `ioStrobe` is 1. An access that is not validated asserts no select (`sramSel`=0, `extCsN`=6'h3F).
- R3: When more than one of `spaceProg`, `spaceData` and `spaceIo` is 1, no select is asserted, whatever the strobes.
- R4: A write lands only when `progEn` and `regWrEn` are both 1 at a rising clock edge. Index 0 selects the SRAM register and indices 1 to 5 select the external registers. Writes with `progEn`=0, or to index 6 or 7, change nothing.
- R5: An external register holds three space enables (bit 0 program, bit 1 data, bit 2 I/O), a 9-bit base block in bits 11:3 and a 9-bit compare mask in bits 20:12. Register k matches when the enable bit for the validated space is set and (addr[21:13] XOR base) AND mask is zero. A match drives `extCsN[k]` low.
- R6: When several external registers match, only the lowest-numbered one drives its select. When none matches and the SRAM is not hit, `extCsN[0]` is asserted for every validated access.
- R7: The SRAM register holds, per half, an enable bit, a space bit (0 program, 1 data) and a 9-bit base block whose upper 7 bits are compared with addr[21:15]. Half 0 uses bits 0, 1 and 10:2. Half 1 uses bits 11, 12 and 21:13. `sramSel` is 1 on a validated access in the configured space that hits an enabled half.
- R8: An I/O access never asserts `sramSel`.
- R9: An SRAM hit deasserts all six external selects, even when external registers also match.
- R10: With bit 22 of the SRAM register clear, `fwdCycle` is always 1. With it set, `fwdCycle` is 0 exactly when `sramSel` is 1.
- R11: Selects are combinational. Removing the strobe deasserts them in the same cycle, with no clock edge in between.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for configuration writes |
| rstN | input | 1 | Active-low asynchronous reset |
| progEn | input | 1 | Program enable; writes are accepted only while high |
| regWrEn | input | 1 | Register write strobe |
| regAddr | input | 3 | Register index |
| regWrData | input | 23 | Register write data |
| spaceProg | input | 1 | Program-space access (active high) |
| spaceData | input | 1 | Data-space access (active high) |
| spaceIo | input | 1 | I/O-space access (active high) |
| memStrobe | input | 1 | Memory strobe (active high) |
| ioStrobe | input | 1 | I/O strobe (active high) |
| addr | input | 22 | Word address |
| sramSel | output | 1 | Internal SRAM select |
| extCsN | output | 6 | External chip selects, active low; bit 0 is the default |
| fwdCycle | output | 1 | Forward this cycle to the secondary bus |

## Verification
An SRAM hit and an external window match can fall on the same access. The bench provokes this by programming a program-space SRAM half and two overlapping program-space external windows over the same block range. It then judges that only `sramSel` is asserted and that all six external selects stay high. A second collision is between two external windows. Here an access that both windows match must assert only the lower-numbered select, and an access that only the higher-numbered window matches must assert that window's select alone.

// File: rtl/spdec_pkg.sv
package spdec_pkg;
  localparam int ADDR_W  = 22;
  localparam int BLK_LSB = 13;
  localparam int BLK_W   = ADDR_W - BLK_LSB;
  localparam int HALF_LSB = 15;
  localparam int HALF_W  = ADDR_W - HALF_LSB;
  localparam int NUM_EXT = 5;
  localparam int NUM_CS  = NUM_EXT + 1;
  localparam int RA_W    = 3;

  typedef struct packed {
    logic prog;
    logic data;
    logic io;
  } spaceStb_t;

  typedef struct packed {
    logic [BLK_W-1:0] mask;
    logic [BLK_W-1:0] base;
    logic             enIo;
    logic             enData;
    logic             enProg;
  } extReg_t;

  typedef struct packed {
    logic             hide;
    logic [BLK_W-1:0] base1;
    logic             sp1;
    logic             en1;
    logic [BLK_W-1:0] base0;
    logic             sp0;
    logic             en0;
  } sramReg_t;

  localparam int CFG_W = $bits(sramReg_t);
  localparam int EXT_W = $bits(extReg_t);
endpackage

// File: rtl/spdec_ctrl.sv
module spdec_ctrl
  import spdec_pkg::*;
(
  input  logic                        clk,
  input  logic                        rstN,
  input  logic                        progEn,
  input  logic                        regWrEn,
  input  logic [RA_W-1:0]             regAddr,
  input  logic [CFG_W-1:0]            regWrData,
  input  logic                        spaceProg,
  input  logic                        spaceData,
  input  logic                        spaceIo,
  input  logic                        memStrobe,
  input  logic                        ioStrobe,
  output spaceStb_t                   stb,
  output sramReg_t                    sramCfg,
  output extReg_t [NUM_EXT-1:0]       extCfg
);
  logic wrOk;
  logic onlyOne;

  assign wrOk = progEn & regWrEn;

  // SRAM placement register, index 0
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sramCfg <= '0;
    end else if (wrOk && regAddr == RA_W'(0)) begin
      sramCfg <= sramReg_t'(regWrData);
    end
  end

  // External window registers, indices 1..NUM_EXT
  for (genvar k = 0; k < NUM_EXT; k++) begin : g_ext
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        extCfg[k] <= '0;
      end else if (wrOk && regAddr == RA_W'(k + 1)) begin
        extCfg[k] <= extReg_t'(regWrData[EXT_W-1:0]);
      end
    end
  end

  // Exactly one space active, then validated by its own strobe type
  assign onlyOne  = ({spaceProg, spaceData, spaceIo} == 3'b100) ||
                    ({spaceProg, spaceData, spaceIo} == 3'b010) ||
                    ({spaceProg, spaceData, spaceIo} == 3'b001);
  assign stb.prog = onlyOne & spaceProg & memStrobe;
  assign stb.data = onlyOne & spaceData & memStrobe;
  assign stb.io   = onlyOne & spaceIo   & ioStrobe;
endmodule

// File: rtl/spdec_match.sv
module spdec_match
  import spdec_pkg::*;
(
  input  spaceStb_t             stb,
  input  sramReg_t              sramCfg,
  input  extReg_t [NUM_EXT-1:0] extCfg,
  input  logic [ADDR_W-1:0]     addr,
  output logic                  sramSel,
  output logic [NUM_CS-1:0]     extCsN,
  output logic                  fwdCycle
);
  logic [BLK_W-1:0]   blk;
  logic [HALF_W-1:0]  halfTag;
  logic               hit0, hit1, anyValid;
  logic [NUM_EXT-1:0] extHit;
  logic [NUM_EXT-1:0] grant;
  logic [NUM_CS-1:0]  sel;

  assign blk      = addr[ADDR_W-1:BLK_LSB];
  assign halfTag  = addr[ADDR_W-1:HALF_LSB];
  assign anyValid = stb.prog | stb.data | stb.io;

  // Internal halves: memory spaces only, never I/O
  assign hit0 = sramCfg.en0 & (sramCfg.sp0 ? stb.data : stb.prog) &
                (halfTag == sramCfg.base0[BLK_W-1:HALF_LSB-BLK_LSB]);
  assign hit1 = sramCfg.en1 & (sramCfg.sp1 ? stb.data : stb.prog) &
                (halfTag == sramCfg.base1[BLK_W-1:HALF_LSB-BLK_LSB]);
  assign sramSel = hit0 | hit1;

  for (genvar k = 0; k < NUM_EXT; k++) begin : g_win
    logic spaceOk;
    assign spaceOk   = (extCfg[k].enProg & stb.prog) |
                       (extCfg[k].enData & stb.data) |
                       (extCfg[k].enIo   & stb.io);
    assign extHit[k] = spaceOk &
                       (((blk ^ extCfg[k].base) & extCfg[k].mask) == '0);
  end

  // Lowest-numbered matching window wins
  always_comb begin
    logic taken;
    taken = 1'b0;
    grant = '0;
    for (int k = 0; k < NUM_EXT; k++) begin
      if (extHit[k] && !taken) begin
        grant[k] = 1'b1;
        taken    = 1'b1;
      end
    end
  end

  assign sel[0]         = anyValid & ~sramSel & ~(|extHit);
  assign sel[NUM_CS-1:1] = sramSel ? '0 : grant;
  assign extCsN         = ~sel;
  assign fwdCycle       = ~(sramCfg.hide & sramSel);
endmodule

// File: rtl/spdec_top.sv
module spdec_top
  import spdec_pkg::*;
(
  input  logic               clk,
  input  logic               rstN,
  input  logic               progEn,
  input  logic               regWrEn,
  input  logic [RA_W-1:0]    regAddr,
  input  logic [CFG_W-1:0]   regWrData,
  input  logic               spaceProg,
  input  logic               spaceData,
  input  logic               spaceIo,
  input  logic               memStrobe,
  input  logic               ioStrobe,
  input  logic [ADDR_W-1:0]  addr,
  output logic               sramSel,
  output logic [NUM_CS-1:0]  extCsN,
  output logic               fwdCycle
);
  spaceStb_t             stb;
  sramReg_t              sramCfg;
  extReg_t [NUM_EXT-1:0] extCfg;

  spdec_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .progEn(progEn), .regWrEn(regWrEn),
    .regAddr(regAddr), .regWrData(regWrData),
    .spaceProg(spaceProg), .spaceData(spaceData), .spaceIo(spaceIo),
    .memStrobe(memStrobe), .ioStrobe(ioStrobe),
    .stb(stb), .sramCfg(sramCfg), .extCfg(extCfg)
  );

  spdec_match u_match (
    .stb(stb), .sramCfg(sramCfg), .extCfg(extCfg), .addr(addr),
    .sramSel(sramSel), .extCsN(extCsN), .fwdCycle(fwdCycle)
  );
endmodule

// File: rtl/spdec_chk.sv
module spdec_chk
  import spdec_pkg::*;
(
  input logic              clk,
  input logic              rstN,
  input logic              spaceProg,
  input logic              spaceData,
  input logic              spaceIo,
  input logic              memStrobe,
  input logic              ioStrobe,
  input logic              sramSel,
  input logic [NUM_CS-1:0] extCsN,
  input logic              fwdCycle
);
  AST_CS_ONEHOT: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(~extCsN)); // R6
  AST_SRAM_EXCL: assert property (@(posedge clk) disable iff (!rstN)
    sramSel |-> (extCsN == '1)); // R9
  AST_IO_NO_SRAM: assert property (@(posedge clk) disable iff (!rstN)
    spaceIo |-> !sramSel); // R8
  AST_NO_STROBE: assert property (@(posedge clk) disable iff (!rstN)
    (!memStrobe && !ioStrobe) |-> (!sramSel && extCsN == '1)); // R2
  AST_MULTI_SPACE: assert property (@(posedge clk) disable iff (!rstN)
    ($countones({spaceProg, spaceData, spaceIo}) > 1) |->
      (!sramSel && extCsN == '1)); // R3
  AST_FWD_SRAM: assert property (@(posedge clk) disable iff (!rstN)
    !fwdCycle |-> sramSel); // R10
endmodule

bind spdec_top spdec_chk u_chk (.*);

// File: tb/tb_spdec_top.sv
module tb_spdec_top;
  localparam time PERIOD = 10ns;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        progEn = 1'b0, regWrEn = 1'b0;
  logic [2:0]  regAddr = '0;
  logic [22:0] regWrData = '0;
  logic        spaceProg = 0, spaceData = 0, spaceIo = 0;
  logic        memStrobe = 0, ioStrobe = 0;
  logic [21:0] addr = '0;
  logic        sramSel, fwdCycle;
  logic [5:0]  extCsN;
  int checks = 0, errors = 0;
  bit done = 0;

  always #(PERIOD/2) clk = ~clk;

  spdec_top dut (.*);

  task automatic chk(string req, logic expS, logic [5:0] expCs, logic expF);
    checks++;
    if (sramSel !== expS || extCsN !== expCs || fwdCycle !== expF) begin
      errors++;
      $display("FAIL %s: sramSel=%b extCsN=%b fwdCycle=%b expected %b %b %b",
               req, sramSel, extCsN, fwdCycle, expS, expCs, expF);
    end
  endtask

  task automatic wrReg(logic en, logic [2:0] idx, logic [22:0] val);
    @(negedge clk);
    progEn = en; regWrEn = 1'b1; regAddr = idx; regWrData = val;
    @(negedge clk);
    progEn = 1'b0; regWrEn = 1'b0;
  endtask

  // space = {prog,data,io}
  task automatic acc(logic [2:0] sp, logic ms, logic ios, logic [8:0] blk);
    @(negedge clk);
    {spaceProg, spaceData, spaceIo} = sp;
    memStrobe = ms; ioStrobe = ios;
    addr = {blk, 13'h0};
    #1;
  endtask

  task automatic idle();
    @(negedge clk);
    {spaceProg, spaceData, spaceIo} = 3'b000; memStrobe = 0; ioStrobe = 0;
  endtask

  task automatic t_reset();
    acc(3'b010, 1, 0, 9'h000); chk("R1 data after reset", 0, 6'b111110, 1);
    acc(3'b100, 1, 0, 9'h012); chk("R1 prog after reset", 0, 6'b111110, 1);
  endtask

  task automatic t_strobe();
    acc(3'b100, 0, 1, 9'h0); chk("R2 prog with io strobe", 0, 6'h3F, 1);
    acc(3'b001, 1, 0, 9'h0); chk("R2 io with mem strobe", 0, 6'h3F, 1);
    acc(3'b001, 0, 1, 9'h0); chk("R2 io validated", 0, 6'b111110, 1);
  endtask

  task automatic t_multi();
    acc(3'b110, 1, 1, 9'h0); chk("R3 prog+data", 0, 6'h3F, 1);
    acc(3'b011, 1, 1, 9'h0); chk("R3 data+io", 0, 6'h3F, 1);
  endtask

  task automatic t_windows();
    wrReg(1, 3'd1, 23'h1F0081); // prog, base 0x010, mask 0x1F0
    wrReg(1, 3'd2, 23'h1F8083); // prog|data, base 0x010, mask 0x1F8
    wrReg(1, 3'd3, 23'h1FF004); // io, base 0, exact
    acc(3'b100, 1, 0, 9'h012); chk("R6 overlap lowest wins", 0, 6'b111101, 1);
    acc(3'b010, 1, 0, 9'h012); chk("R5 data window 2", 0, 6'b111011, 1);
    acc(3'b100, 1, 0, 9'h018); chk("R5 prog window 1 only", 0, 6'b111101, 1);
    acc(3'b010, 1, 0, 9'h018); chk("R6 default no match", 0, 6'b111110, 1);
    acc(3'b001, 0, 1, 9'h000); chk("R5 io window 3", 0, 6'b110111, 1);
  endtask

  task automatic t_lock();
    wrReg(0, 3'd4, 23'h000002);
    acc(3'b010, 1, 0, 9'h018); chk("R4 write without progEn", 0, 6'b111110, 1);
    wrReg(1, 3'd6, 23'h000002);
    wrReg(1, 3'd7, 23'h000002);
    acc(3'b010, 1, 0, 9'h018); chk("R4 write to index 6/7", 0, 6'b111110, 1);
  endtask

  task automatic t_sram();
    wrReg(1, 3'd0, 23'h020883); // half0 data @0x020, half1 prog @0x010
    acc(3'b010, 1, 0, 9'h021); chk("R7 data half0 hit", 1, 6'h3F, 1);
    acc(3'b100, 1, 0, 9'h021); chk("R7 wrong space miss", 0, 6'b111110, 1);
    acc(3'b100, 1, 0, 9'h012); chk("R9 sram overrides windows", 1, 6'h3F, 1);
    acc(3'b001, 0, 1, 9'h020); chk("R8 io never sram", 0, 6'b111110, 1);
  endtask

  task automatic t_forward();
    wrReg(1, 3'd0, 23'h420883);
    acc(3'b100, 1, 0, 9'h012); chk("R10 hidden sram hit", 1, 6'h3F, 0);
    acc(3'b010, 1, 0, 9'h018); chk("R10 miss forwarded", 0, 6'b111110, 1);
  endtask

  task automatic t_comb();
    acc(3'b100, 1, 0, 9'h018); chk("R11 strobe on", 0, 6'b111101, 1);
    memStrobe = 0; #1;
    chk("R11 strobe off same cycle", 0, 6'h3F, 1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    #1 chk("R1 reset idle", 0, 6'h3F, 1);
    t_reset();
    t_strobe();
    t_multi();
    t_windows();
    t_lock();
    t_sram();
    t_forward();
    t_comb();
    idle();
    repeat (2) @(negedge clk);
    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    #(PERIOD * 20000);
    if (!done) begin
      done = 1;
      checks++; errors++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule